// File: doc/BRIEF.md
# Keyboard Controller Host Command Decoder

This block sits on the host side of a PC-style keyboard controller. The host reaches it over a byte-wide write bus with a single select bit. Select high means the command/status port and select low means the data port. Each command byte is decoded in the cycle it is written. The block keeps the controller mode byte and the output-port byte, and it remembers which command, if any, is waiting for an operand on the data port.

Several things come out of a decoded write. Response bytes go to the output-buffer logic, each tagged as keyboard-type or mouse-type. Bytes bound for the keyboard or the mouse go out on separate transmit strobes. The block also drives an A20 gate level, which follows output-port bit 1. A system reset request is issued as a single-cycle pulse.

The status byte is presented as a plain level, so reading it has no side effects. Arbitration of the output buffer and the interrupt lines live in neighbouring logic. That logic reads `modeByte` and the response strobe.

Top module: `kbc_host_decoder`

## Requirements
- R1: After reset, `modeByte` is 0x03, `statusByte` is 0x18 (bit 3 last-write-was-command, bit 4 unlocked), `outPort` is 0xCF and `a20Gate` is 1. At the same time every strobe output (`rspValid`, `kbdTxValid`, `auxTxValid`, `resetReq`, `cmdError`) is 0.
- R2: `statusByte` is a plain level. Among all command codes, only 0xAA changes it.
- R3: Query commands produce one response with `rspAux`=0. 0x20 returns the mode byte, 0xD0 returns the output-port byte, 0xC0 returns 0x80, and both 0xA9 and 0xAB return 0x00.
- R4: Command 0xAA sets status bit 2 (0x18 becomes 0x1C), and the bit stays set until reset. The command also returns response 0x55.
- R5: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 each take the next data-port write as their operand. After that single write the pending command is cleared, so the following data write goes to the keyboard.
- R6: The 0x60 operand becomes the mode byte. The 0xD1 operand becomes the output-port byte. `a20Gate` then follows operand bit 1, and a reset pulse is issued when operand bit 0 is 0.
- R7: The 0xD2 operand is returned as a response with `rspAux`=0. The 0xD3 operand is returned with `rspAux`=1.
- R8: The 0xD4 operand is sent on the mouse transmit strobe, and mode bit 5 is cleared.
- R9: A data write with no pending command is sent on the keyboard transmit strobe, and mode bit 4 is cleared.
- R10: 0xA7 sets mode bit 5 and 0xA8 clears it. 0xAD sets mode bit 4 and 0xAE clears it.
- R11: A command with bits 7:4 all ones is a pulse command. If its bit 0 is 0 it raises `resetReq` for one cycle. Otherwise it changes nothing.
- R12: 0xDF sets output-port bit 1 and drives `a20Gate` high. 0xDD clears that bit and drives `a20Gate` low.
- R13: Any other command code raises `cmdError` for one cycle and changes no state.
- R14: Every result appears in the cycle after the write that caused it. `resetReq`, `cmdError` and all valid strobes are high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrCmd | input | 1 | Port select: 1 command/status, 0 data |
| wrData | input | 8 | Written byte |
| statusByte | output | 8 | Status byte seen on a status read |
| modeByte | output | 8 | Controller mode byte |
| outPort | output | 8 | Output-port byte |
| a20Gate | output | 1 | A20 gate level |
| resetReq | output | 1 | One-cycle system reset request |
| cmdError | output | 1 | One-cycle unsupported-command flag |
| rspValid | output | 1 | Response byte strobe |
| rspData | output | 8 | Response byte |
| rspAux | output | 1 | Response is mouse-type |
| kbdTxValid | output | 1 | Keyboard-bound byte strobe |
| kbdTxData | output | 8 | Keyboard-bound byte |
| auxTxValid | output | 1 | Mouse-bound byte strobe |
| auxTxData | output | 8 | Mouse-bound byte |

## Verification
The decode is combinational and the result registers sit behind a single flop stage. Every strobe and state change caused by a write is therefore due exactly one clock edge after that write. The bench drives each write on a falling edge and removes it on the next falling edge. It samples all outputs at that same falling edge, which is exactly when the result is due. One further idle cycle then confirms that every pulse has dropped again. Because of this timing, a missing or a doubled flop stage shows up as a wrong value rather than a late one.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] MODE_RST   = 8'h03;
  localparam logic [BYTE_W-1:0] STATUS_RST = 8'h18;
  localparam logic [BYTE_W-1:0] OUTP_RST   = 8'hCF;

  localparam int MODE_KBD_DIS_BIT = 4;
  localparam int MODE_AUX_DIS_BIT = 5;
  localparam int OUTP_A20_BIT     = 1;
  localparam int OUTP_RUN_BIT     = 0;
  localparam int STAT_TEST_BIT    = 2;

  localparam logic [BYTE_W-1:0] C_RD_MODE   = 8'h20;
  localparam logic [BYTE_W-1:0] C_WR_MODE   = 8'h60;
  localparam logic [BYTE_W-1:0] C_AUX_OFF   = 8'hA7;
  localparam logic [BYTE_W-1:0] C_AUX_ON    = 8'hA8;
  localparam logic [BYTE_W-1:0] C_AUX_TEST  = 8'hA9;
  localparam logic [BYTE_W-1:0] C_SELFTEST  = 8'hAA;
  localparam logic [BYTE_W-1:0] C_KBD_TEST  = 8'hAB;
  localparam logic [BYTE_W-1:0] C_KBD_OFF   = 8'hAD;
  localparam logic [BYTE_W-1:0] C_KBD_ON    = 8'hAE;
  localparam logic [BYTE_W-1:0] C_RD_INP    = 8'hC0;
  localparam logic [BYTE_W-1:0] C_RD_OUTP   = 8'hD0;
  localparam logic [BYTE_W-1:0] C_WR_OUTP   = 8'hD1;
  localparam logic [BYTE_W-1:0] C_ECHO_KBD  = 8'hD2;
  localparam logic [BYTE_W-1:0] C_ECHO_AUX  = 8'hD3;
  localparam logic [BYTE_W-1:0] C_TO_AUX    = 8'hD4;
  localparam logic [BYTE_W-1:0] C_A20_LOW   = 8'hDD;
  localparam logic [BYTE_W-1:0] C_A20_HIGH  = 8'hDF;

  localparam logic [BYTE_W-1:0] SELFTEST_OK = 8'h55;
  localparam logic [BYTE_W-1:0] INPORT_VAL  = 8'h80;
  localparam logic [BYTE_W-1:0] TEST_OK     = 8'h00;

  typedef enum logic [1:0] {
    SRC_CONST,
    SRC_MODE,
    SRC_OUTP,
    SRC_WDATA
  } rspSrc_e;

  typedef struct packed {
    logic              rspEn;
    rspSrc_e           rspSrc;
    logic [BYTE_W-1:0] rspConst;
    logic              rspAux;
    logic              modeLoad;
    logic              kbdDisSet;
    logic              kbdDisClr;
    logic              auxDisSet;
    logic              auxDisClr;
    logic              outpLoad;
    logic              a20Set;
    logic              a20Clr;
    logic              selfTestSet;
    logic              kbdTx;
    logic              auxTx;
    logic              resetPulse;
    logic              errPulse;
  } ctrlStrb_t;
endpackage

// File: rtl/kbc_cmd_ctrl.sv
module kbc_cmd_ctrl
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrCmd,
  input  logic [BYTE_W-1:0] wrData,
  output ctrlStrb_t         strb
);
  localparam logic [3:0] PULSE_NIB = 4'hF;

  logic [BYTE_W-1:0] pendCmd;
  logic              isArming;

  always_comb begin
    isArming = (wrData == C_WR_MODE)  || (wrData == C_WR_OUTP) ||
               (wrData == C_ECHO_KBD) || (wrData == C_ECHO_AUX) ||
               (wrData == C_TO_AUX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCmd <= '0;
    end else if (wrEn && wrCmd && isArming) begin
      pendCmd <= wrData;
    end else if (wrEn && !wrCmd) begin
      pendCmd <= '0;
    end
  end

  always_comb begin
    strb = '0;
    if (wrEn && wrCmd) begin
      if (wrData[BYTE_W-1 -: 4] == PULSE_NIB) begin
        strb.resetPulse = !wrData[0];
      end else begin
        unique case (wrData)
          C_RD_MODE: begin
            strb.rspEn  = 1'b1;
            strb.rspSrc = SRC_MODE;
          end
          C_RD_OUTP: begin
            strb.rspEn  = 1'b1;
            strb.rspSrc = SRC_OUTP;
          end
          C_SELFTEST: begin
            strb.rspEn       = 1'b1;
            strb.rspConst    = SELFTEST_OK;
            strb.selfTestSet = 1'b1;
          end
          C_AUX_TEST, C_KBD_TEST: begin
            strb.rspEn    = 1'b1;
            strb.rspConst = TEST_OK;
          end
          C_RD_INP: begin
            strb.rspEn    = 1'b1;
            strb.rspConst = INPORT_VAL;
          end
          C_AUX_OFF:  strb.auxDisSet = 1'b1;
          C_AUX_ON:   strb.auxDisClr = 1'b1;
          C_KBD_OFF:  strb.kbdDisSet = 1'b1;
          C_KBD_ON:   strb.kbdDisClr = 1'b1;
          C_A20_HIGH: strb.a20Set    = 1'b1;
          C_A20_LOW:  strb.a20Clr    = 1'b1;
          C_WR_MODE, C_WR_OUTP, C_ECHO_KBD, C_ECHO_AUX, C_TO_AUX: ;
          default:    strb.errPulse  = 1'b1;
        endcase
      end
    end else if (wrEn) begin
      unique case (pendCmd)
        C_WR_MODE: strb.modeLoad = 1'b1;
        C_WR_OUTP: begin
          strb.outpLoad   = 1'b1;
          strb.resetPulse = !wrData[OUTP_RUN_BIT];
        end
        C_ECHO_KBD: begin
          strb.rspEn  = 1'b1;
          strb.rspSrc = SRC_WDATA;
        end
        C_ECHO_AUX: begin
          strb.rspEn  = 1'b1;
          strb.rspSrc = SRC_WDATA;
          strb.rspAux = 1'b1;
        end
        C_TO_AUX: begin
          strb.auxTx     = 1'b1;
          strb.auxDisClr = 1'b1;
        end
        default: begin
          strb.kbdTx     = 1'b1;
          strb.kbdDisClr = 1'b1;
        end
      endcase
    end
  end

  AST_PEND_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (pendCmd == '0) || (pendCmd == C_WR_MODE) || (pendCmd == C_WR_OUTP) ||
    (pendCmd == C_ECHO_KBD) || (pendCmd == C_ECHO_AUX) || (pendCmd == C_TO_AUX)); // R5
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrCmd) |=> (pendCmd == '0)); // R5
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rspEn, strb.kbdTx, strb.auxTx, strb.errPulse})); // R14
endmodule

// File: rtl/kbc_cmd_datapath.sv
module kbc_cmd_datapath
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] statusByte,
  output logic [BYTE_W-1:0] modeByte,
  output logic [BYTE_W-1:0] outPort,
  output logic              resetReq,
  output logic              cmdError,
  output logic              rspValid,
  output logic [BYTE_W-1:0] rspData,
  output logic              rspAux,
  output logic              kbdTxValid,
  output logic [BYTE_W-1:0] kbdTxData,
  output logic              auxTxValid,
  output logic [BYTE_W-1:0] auxTxData
);
  logic [BYTE_W-1:0] rspNext;

  always_comb begin
    unique case (strb.rspSrc)
      SRC_MODE:  rspNext = modeByte;
      SRC_OUTP:  rspNext = outPort;
      SRC_WDATA: rspNext = wrData;
      default:   rspNext = strb.rspConst;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeByte <= MODE_RST;
    end else if (strb.modeLoad) begin
      modeByte <= wrData;
    end else begin
      if (strb.kbdDisSet) modeByte[MODE_KBD_DIS_BIT] <= 1'b1;
      if (strb.kbdDisClr) modeByte[MODE_KBD_DIS_BIT] <= 1'b0;
      if (strb.auxDisSet) modeByte[MODE_AUX_DIS_BIT] <= 1'b1;
      if (strb.auxDisClr) modeByte[MODE_AUX_DIS_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPort <= OUTP_RST;
    end else if (strb.outpLoad) begin
      outPort <= wrData;
    end else if (strb.a20Set) begin
      outPort[OUTP_A20_BIT] <= 1'b1;
    end else if (strb.a20Clr) begin
      outPort[OUTP_A20_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusByte <= STATUS_RST;
    end else if (strb.selfTestSet) begin
      statusByte[STAT_TEST_BIT] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspData    <= '0;
      rspAux     <= 1'b0;
      kbdTxValid <= 1'b0;
      kbdTxData  <= '0;
      auxTxValid <= 1'b0;
      auxTxData  <= '0;
      resetReq   <= 1'b0;
      cmdError   <= 1'b0;
    end else begin
      rspValid   <= strb.rspEn;
      kbdTxValid <= strb.kbdTx;
      auxTxValid <= strb.auxTx;
      resetReq   <= strb.resetPulse;
      cmdError   <= strb.errPulse;
      if (strb.rspEn) begin
        rspData <= rspNext;
        rspAux  <= strb.rspAux;
      end
      if (strb.kbdTx) kbdTxData <= wrData;
      if (strb.auxTx) auxTxData <= wrData;
    end
  end

  AST_SELFTEST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[STAT_TEST_BIT] |=> statusByte[STAT_TEST_BIT]); // R4
  AST_KBD_TX_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    kbdTxValid |-> !modeByte[MODE_KBD_DIS_BIT]); // R9
  AST_AUX_TX_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    auxTxValid |-> !modeByte[MODE_AUX_DIS_BIT]); // R8
  AST_ERR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> $stable(modeByte)); // R13
endmodule

// File: rtl/kbc_host_decoder.sv
module kbc_host_decoder
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrCmd,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] statusByte,
  output logic [BYTE_W-1:0] modeByte,
  output logic [BYTE_W-1:0] outPort,
  output logic              a20Gate,
  output logic              resetReq,
  output logic              cmdError,
  output logic              rspValid,
  output logic [BYTE_W-1:0] rspData,
  output logic              rspAux,
  output logic              kbdTxValid,
  output logic [BYTE_W-1:0] kbdTxData,
  output logic              auxTxValid,
  output logic [BYTE_W-1:0] auxTxData
);
  ctrlStrb_t strb;

  kbc_cmd_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrCmd  (wrCmd),
    .wrData (wrData),
    .strb   (strb)
  );

  kbc_cmd_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .statusByte (statusByte),
    .modeByte   (modeByte),
    .outPort    (outPort),
    .resetReq   (resetReq),
    .cmdError   (cmdError),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .rspAux     (rspAux),
    .kbdTxValid (kbdTxValid),
    .kbdTxData  (kbdTxData),
    .auxTxValid (auxTxValid),
    .auxTxData  (auxTxData)
  );

  assign a20Gate = outPort[OUTP_A20_BIT];

  AST_RESET_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(wrEn)); // R11
  AST_ERR_FROM_CMD: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> $past(wrEn && wrCmd)); // R13
  AST_KBD_FROM_DATA: assert property (@(posedge clk) disable iff (!rstN)
    kbdTxValid |-> $past(wrEn && !wrCmd)); // R9
endmodule

// File: tb/kbc_host_decoder_tb.sv
`timescale 1ns/1ps
module kbc_host_decoder_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrCmd = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] statusByte, modeByte, outPort, rspData, kbdTxData, auxTxData;
  logic       a20Gate, resetReq, cmdError, rspValid, rspAux, kbdTxValid, auxTxValid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  kbc_host_decoder u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCmd(wrCmd), .wrData(wrData),
    .statusByte(statusByte), .modeByte(modeByte), .outPort(outPort),
    .a20Gate(a20Gate), .resetReq(resetReq), .cmdError(cmdError),
    .rspValid(rspValid), .rspData(rspData), .rspAux(rspAux),
    .kbdTxValid(kbdTxValid), .kbdTxData(kbdTxData),
    .auxTxValid(auxTxValid), .auxTxData(auxTxData)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    wrEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Drives one write; returns at the falling edge where its result is due.
  task automatic doWrite(input logic isCmd, input logic [7:0] val);
    @(negedge clk);
    wrEn = 1'b1;
    wrCmd = isCmd;
    wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idleCheck(input string req);
    @(negedge clk);
    chk(req, {3'b0, resetReq, cmdError, rspValid, kbdTxValid, auxTxValid}, 8'h00);
  endtask

  function automatic bit isKnown(input logic [7:0] c);
    if (c[7:4] == 4'hF) return 1'b1;
    case (c)
      8'h20, 8'h60, 8'hA7, 8'hA8, 8'hA9, 8'hAA, 8'hAB, 8'hAD, 8'hAE,
      8'hC0, 8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hDD, 8'hDF: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit isArm(input logic [7:0] c);
    return (c == 8'h60) || (c == 8'hD1) || (c == 8'hD2) || (c == 8'hD3) || (c == 8'hD4);
  endfunction

  initial begin
    logic [8:0] rspExp;
    logic [7:0] modeExp, outExp, statExp;
    doReset();
    // R1 reset state
    @(negedge clk);
    chk("R1 mode", modeByte, 8'h03);
    chk("R1 status", statusByte, 8'h18);
    chk("R1 outport", outPort, 8'hCF);
    chk("R1 a20", {7'b0, a20Gate}, 8'h01);
    chk("R1 strobes", {3'b0, resetReq, cmdError, rspValid, kbdTxValid, auxTxValid}, 8'h00);

    // Exhaustive command sweep from reset: R2 R3 R4 R10 R11 R12 R13 R14
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cb;
      cb = c[7:0];
      doReset();
      if (cb == 8'hD4) doWrite(1'b1, 8'hA7);
      doWrite(1'b1, cb);
      chk("R13 cmdError", {7'b0, cmdError}, {7'b0, !isKnown(cb)});
      chk("R11 resetReq", {7'b0, resetReq},
          {7'b0, (cb[7:4] == 4'hF) && !cb[0]});
      case (cb)
        8'h20: rspExp = {1'b1, 8'h03};
        8'hD0: rspExp = {1'b1, 8'hCF};
        8'hAA: rspExp = {1'b1, 8'h55};
        8'hA9, 8'hAB: rspExp = {1'b1, 8'h00};
        8'hC0: rspExp = {1'b1, 8'h80};
        default: rspExp = 9'h000;
      endcase
      chk("R3 rspValid", {7'b0, rspValid}, {7'b0, rspExp[8]});
      if (rspExp[8]) begin
        chk("R3 rspData", rspData, rspExp[7:0]);
        chk("R3 rspAux", {7'b0, rspAux}, 8'h00);
      end
      case (cb)
        8'hA7: modeExp = 8'h23;
        8'hAD: modeExp = 8'h13;
        8'hD4: modeExp = 8'h23;
        default: modeExp = 8'h03;
      endcase
      chk("R10 mode", modeByte, modeExp);
      outExp = (cb == 8'hDD) ? 8'hCD : 8'hCF;
      chk("R12 outport", outPort, outExp);
      chk("R12 a20", {7'b0, a20Gate}, {7'b0, outExp[1]});
      statExp = (cb == 8'hAA) ? 8'h1C : 8'h18;
      chk("R2 R4 status", statusByte, statExp);
      idleCheck("R14 pulse width");
      if (cb == 8'hAA) chk("R4 status sticky", statusByte, 8'h1C);
      if (isArm(cb)) begin
        doWrite(1'b0, 8'hA5);
        case (cb)
          8'h60: chk("R6 mode load", modeByte, 8'hA5);
          8'hD1: begin
            chk("R6 outport load", outPort, 8'hA5);
            chk("R6 a20 from bit1", {7'b0, a20Gate}, 8'h00);
            chk("R6 no reset bit0=1", {7'b0, resetReq}, 8'h00);
          end
          8'hD2: begin
            chk("R7 D2 valid", {7'b0, rspValid}, 8'h01);
            chk("R7 D2 data", rspData, 8'hA5);
            chk("R7 D2 aux", {7'b0, rspAux}, 8'h00);
          end
          8'hD3: begin
            chk("R7 D3 valid", {7'b0, rspValid}, 8'h01);
            chk("R7 D3 data", rspData, 8'hA5);
            chk("R7 D3 aux", {7'b0, rspAux}, 8'h01);
          end
          default: begin
            chk("R8 aux valid", {7'b0, auxTxValid}, 8'h01);
            chk("R8 aux data", auxTxData, 8'hA5);
            chk("R8 mode bit5", {7'b0, modeByte[5]}, 8'h00);
          end
        endcase
        chk("R5 operand not to keyboard", {7'b0, kbdTxValid}, 8'h00);
        doWrite(1'b0, 8'h3C);
        chk("R5 pending cleared", {7'b0, kbdTxValid}, 8'h01);
        chk("R5 kbd data", kbdTxData, 8'h3C);
        chk("R5 no echo", {7'b0, rspValid | auxTxValid}, 8'h00);
      end
    end

    // Mode byte load and read back over all values: R6 R3
    doReset();
    for (int v = 0; v < 256; v++) begin
      doWrite(1'b1, 8'h60);
      doWrite(1'b0, v[7:0]);
      chk("R6 mode sweep", modeByte, v[7:0]);
      doWrite(1'b1, 8'h20);
      chk("R3 mode readback", rspData, v[7:0]);
    end

    // Output port writes over bits 1:0: R6
    for (int b = 0; b < 4; b++) begin
      logic [7:0] ov;
      ov = 8'hCC | b[7:0];
      doReset();
      doWrite(1'b1, 8'hD1);
      doWrite(1'b0, ov);
      chk("R6 outport", outPort, ov);
      chk("R6 a20", {7'b0, a20Gate}, {7'b0, ov[1]});
      chk("R6 reset from bit0", {7'b0, resetReq}, {7'b0, !ov[0]});
      idleCheck("R14 reset pulse width");
      doWrite(1'b1, 8'hD0);
      chk("R3 outport readback", rspData, ov);
    end

    // Keyboard disable released by data write: R9 R10
    doReset();
    doWrite(1'b1, 8'hAD);
    chk("R10 kbd disabled", {7'b0, modeByte[4]}, 8'h01);
    doWrite(1'b0, 8'h11);
    chk("R9 kbd tx", {7'b0, kbdTxValid}, 8'h01);
    chk("R9 kbd data", kbdTxData, 8'h11);
    chk("R9 bit4 cleared", {7'b0, modeByte[4]}, 8'h00);

    // Unsupported command after state change leaves everything alone: R13
    doWrite(1'b1, 8'hDD);
    doWrite(1'b1, 8'hA1);
    chk("R13 error", {7'b0, cmdError}, 8'h01);
    chk("R13 outport kept", outPort, 8'hCD);
    chk("R13 mode kept", modeByte, 8'h03);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule